// File: doc/BRIEF.md
# DMA Queue Reset Sequencer

This block is a small bus master. It drives one hardware DMA queue into a clean idle state by running a fixed series of accesses on a simple 32-bit register bus. The bus has an address, write data, read data, a request and an acknowledge. A start pulse selects a queue index and a layout bit, and these two values fix the address of every register the block touches. The block ends with a one-cycle done pulse and an error flag that reports whether a status poll timed out.

Every change to a single control bit is made in two accesses: a read of the word, then a write of the same word with only the one bit altered. The sequence does the following, in order:

1. Pause the queue.
2. Disable the queue.
3. Wait until the queue state machine has left the running state.
4. Assert the queue reset bit.
5. Zero the submit-tail pointer and the completion-head pointer.
6. Release the pause.
7. Wait until the queue state machine reports idle.

Both waits read the status register at a fixed interval and give up after a bounded number of reads.

Top module: `qrst_seq`

## Requirements
- R1: Every access goes to base + qidx*0x100 + offset, where base is BASE_L0 when layout_i=0 and BASE_L1 when layout_i=1 (both default 0). The register offsets are: control-0 at 0x20, control-1 at 0x24, status at 0x30, submit tail at 0x0C and completion head at 0x1C. qidx and layout are captured at start.
- R2: After start, the accesses are issued in this order:
  1. Control-0: read, then write with bit 4 set.
  2. Control-0: read, then write with bit 0 cleared.
  3. First poll of the status register.
  4. Control-1: read, then write with bit 0 set.
  5. Submit tail: write of 0.
  6. Completion head: write of 0.
  7. Control-0: read, then write with bit 4 cleared.
  8. Second poll of the status register.
- R3: Each bit update reads a word and then writes the same address. The written value equals the value read with only the target bit changed, so all other bits are preserved.
- R4: The first poll ends on the first status read whose bits [3:0] differ from 1 (running). Bits [31:4] are ignored.
- R5: The second poll ends on the first status read whose bits [3:0] equal 0 (idle). Bits [31:4] are ignored.
- R6: When a poll read misses, the next status request is raised POLL_GAP cycles after the cycle that accepted the previous acknowledge. With a responder latency of L cycles, consecutive poll acknowledges are therefore POLL_GAP+1+L cycles apart.
- R7: A poll allows at most POLL_SPAN/POLL_GAP+1 reads. If the last allowed read misses, no further access is issued, and done_o pulses with error_o=1.
- R8: done_o is high for exactly one cycle per started sequence. error_o is 0 for a successful sequence, is valid with done_o, and holds until the next accepted start.
- R9: A start pulse that arrives while a sequence is in progress is ignored. It adds no access, changes no address and produces no extra done pulse.
- R10: Once req_o is raised, it stays high with addr_o, we_o and wdata_o unchanged until ack_i is seen.
- R11: After reset, req_o, done_o and error_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse (accepted only when idle) |
| qidx_i | input | QIDX_W | Queue index |
| layout_i | input | 1 | Register layout select (picks queue base) |
| done_o | output | 1 | One-cycle completion pulse |
| error_o | output | 1 | Poll timeout flag, valid with done_o |
| req_o | output | 1 | Bus request |
| we_o | output | 1 | Bus write enable (0 = read) |
| addr_o | output | ADDR_W | Bus byte address |
| wdata_o | output | 32 | Bus write data |
| rdata_i | input | 32 | Bus read data, valid with ack_i on reads |
| ack_i | input | 1 | Bus acknowledge, one cycle per access |

## Verification
A wrong step counter or step table shows at the ports at once, as an access to the wrong offset or one out of order. The bench compares every access of a run against a list it computes itself. A wrong read-modify-write mask is visible in the very next write, as a data word that differs from the read value in more than the target bit. A poll counter or gap timer that is off by one shows within one poll, either as an acknowledge spacing that differs from POLL_GAP+1+L or as one read too many or too few before the timeout ends the run.

// File: rtl/qrst_pkg.sv
package qrst_pkg;

  localparam int STS_W = 4;
  localparam logic [STS_W-1:0] STS_IDLE = 4'd0;
  localparam logic [STS_W-1:0] STS_RUN  = 4'd1;

  localparam logic [7:0] OFF_SQ_TAIL = 8'h0C;
  localparam logic [7:0] OFF_CQ_HEAD = 8'h1C;
  localparam logic [7:0] OFF_CTL0    = 8'h20;
  localparam logic [7:0] OFF_CTL1    = 8'h24;
  localparam logic [7:0] OFF_STS     = 8'h30;

  localparam logic [2:0] LAST_STEP = 3'd7;

  typedef enum logic [1:0] {OP_RMW, OP_WR0, OP_POLL} op_e;

  typedef struct packed {
    op_e        op;
    logic [7:0] off;
    logic [4:0] bitpos;
    logic       setv;       // RMW: value written to the bit
    logic       want_idle;  // POLL: 1 = wait for idle, 0 = wait for not-running
  } step_t;

  typedef enum logic [2:0] {S_IDLE, S_RD, S_WR, S_WAIT, S_DONE} st_e;

  function automatic step_t step_of(logic [2:0] s);
    case (s)
      3'd0:    return '{OP_RMW,  OFF_CTL0,    5'd4, 1'b1, 1'b0};
      3'd1:    return '{OP_RMW,  OFF_CTL0,    5'd0, 1'b0, 1'b0};
      3'd2:    return '{OP_POLL, OFF_STS,     5'd0, 1'b0, 1'b0};
      3'd3:    return '{OP_RMW,  OFF_CTL1,    5'd0, 1'b1, 1'b0};
      3'd4:    return '{OP_WR0,  OFF_SQ_TAIL, 5'd0, 1'b0, 1'b0};
      3'd5:    return '{OP_WR0,  OFF_CQ_HEAD, 5'd0, 1'b0, 1'b0};
      3'd6:    return '{OP_RMW,  OFF_CTL0,    5'd4, 1'b0, 1'b0};
      default: return '{OP_POLL, OFF_STS,     5'd0, 1'b0, 1'b1};
    endcase
  endfunction

endpackage

// File: rtl/qrst_addr_gen.sv
module qrst_addr_gen #(
  parameter int ADDR_W  = 16,
  parameter int QIDX_W  = 2,
  parameter int REGION  = 256,
  parameter int BASE_L0 = 0,
  parameter int BASE_L1 = 0
) (
  input  logic              layout_i,
  input  logic [QIDX_W-1:0] qidx_i,
  input  logic [7:0]        off_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int SHIFT = $clog2(REGION);
  localparam logic [ADDR_W-1:0] B0 = ADDR_W'(BASE_L0);
  localparam logic [ADDR_W-1:0] B1 = ADDR_W'(BASE_L1);

  logic [ADDR_W-1:0] base;
  assign base   = layout_i ? B1 : B0;
  assign addr_o = base + (ADDR_W'(qidx_i) << SHIFT) + ADDR_W'(off_i);
endmodule

// File: rtl/qrst_poll_ctr.sv
module qrst_poll_ctr #(
  parameter int GAP       = 100,
  parameter int MAX_READS = 101
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,      // not in a poll step
  input  logic rd_i,       // a poll read was acknowledged
  input  logic arm_i,      // start an inter-read gap
  output logic last_o,     // current read is the last one allowed
  output logic gap_done_o
);
  localparam int RC_W = $clog2(MAX_READS + 1);
  localparam int GT_W = $clog2(GAP + 1);

  logic [RC_W-1:0] rd_cnt;
  logic [GT_W-1:0] tmr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    rd_cnt <= '0;
    else if (clr_i) rd_cnt <= '0;
    else if (rd_i)  rd_cnt <= rd_cnt + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          tmr <= '0;
    else if (arm_i)       tmr <= GT_W'(GAP - 1);
    else if (tmr != '0)   tmr <= tmr - 1'b1;
  end

  assign last_o     = (rd_cnt == RC_W'(MAX_READS - 1));
  assign gap_done_o = (tmr == '0);
endmodule

// File: rtl/qrst_seq.sv
module qrst_seq
  import qrst_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int QIDX_W    = 2,
  parameter int POLL_GAP  = 100,
  parameter int POLL_SPAN = 10000,
  parameter int BASE_L0   = 0,
  parameter int BASE_L1   = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [QIDX_W-1:0] qidx_i,
  input  logic              layout_i,
  output logic              done_o,
  output logic              error_o,
  output logic              req_o,
  output logic              we_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [31:0]       wdata_o,
  input  logic [31:0]       rdata_i,
  input  logic              ack_i
);
  localparam int MAX_READS = POLL_SPAN / POLL_GAP + 1;

  st_e               st;
  logic [2:0]        step;
  logic [QIDX_W-1:0] qidx_q;
  logic              lay_q;
  logic [31:0]       wdata_q;
  logic              err_q;

  step_t cur, nxt;
  logic [31:0] mask;
  logic        hit, last_rd, gap_done, poll_rd, poll_miss;

  assign cur  = step_of(step);
  assign nxt  = step_of(step + 3'd1);
  assign mask = 32'h1 << cur.bitpos;
  assign hit  = cur.want_idle ? (rdata_i[STS_W-1:0] == STS_IDLE)
                              : (rdata_i[STS_W-1:0] != STS_RUN);
  assign poll_rd   = (st == S_RD) && ack_i && (cur.op == OP_POLL);
  assign poll_miss = poll_rd && !hit && !last_rd;

  qrst_addr_gen #(
    .ADDR_W(ADDR_W), .QIDX_W(QIDX_W), .REGION(256),
    .BASE_L0(BASE_L0), .BASE_L1(BASE_L1)
  ) u_addr (
    .layout_i(lay_q), .qidx_i(qidx_q), .off_i(cur.off), .addr_o(addr_o)
  );

  qrst_poll_ctr #(.GAP(POLL_GAP), .MAX_READS(MAX_READS)) u_poll (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .clr_i(cur.op != OP_POLL), .rd_i(poll_rd), .arm_i(poll_miss),
    .last_o(last_rd), .gap_done_o(gap_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st      <= S_IDLE;
      step    <= '0;
      qidx_q  <= '0;
      lay_q   <= 1'b0;
      wdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start_i) begin
          qidx_q <= qidx_i;
          lay_q  <= layout_i;
          err_q  <= 1'b0;
          step   <= '0;
          st     <= S_RD;
        end
        S_RD: if (ack_i) begin
          if (cur.op == OP_RMW) begin
            wdata_q <= cur.setv ? (rdata_i | mask) : (rdata_i & ~mask);
            st      <= S_WR;
          end else if (hit) begin
            if (step == LAST_STEP) st <= S_DONE;
            else begin
              step <= step + 3'd1;
              if (nxt.op == OP_WR0) begin wdata_q <= '0; st <= S_WR; end
              else st <= S_RD;
            end
          end else if (last_rd) begin
            err_q <= 1'b1;
            st    <= S_DONE;
          end else begin
            st <= S_WAIT;
          end
        end
        S_WR: if (ack_i) begin
          if (step == LAST_STEP) st <= S_DONE;
          else begin
            step <= step + 3'd1;
            if (nxt.op == OP_WR0) begin wdata_q <= '0; st <= S_WR; end
            else st <= S_RD;
          end
        end
        S_WAIT: if (gap_done) st <= S_RD;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign req_o   = (st == S_RD) || (st == S_WR);
  assign we_o    = (st == S_WR);
  assign wdata_o = wdata_q;
  assign done_o  = (st == S_DONE);
  assign error_o = err_q;
endmodule

// File: rtl/qrst_seq_chk.sv
module qrst_seq_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              done_o,
  input logic              req_o,
  input logic              we_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic [31:0]       wdata_o,
  input logic              ack_i
);
  p_req_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !ack_i) |=> (req_o && $stable(addr_o) && $stable(we_o) && $stable(wdata_o)));

  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_quiet_after_done_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !req_o);

  p_offset_set_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> (addr_o[7:0] inside {8'h0C, 8'h1C, 8'h20, 8'h24, 8'h30}));

  p_ptr_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && we_o && (addr_o[7:0] inside {8'h0C, 8'h1C})) |-> (wdata_o == 32'h0));

  p_sts_read_only_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && addr_o[7:0] == 8'h30) |-> !we_o);
endmodule

bind qrst_seq qrst_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .done_o(done_o), .req_o(req_o), .we_o(we_o),
  .addr_o(addr_o), .wdata_o(wdata_o), .ack_i(ack_i)
);

// File: tb/sim_qrst_seq.sv
module sim_qrst_seq;
  localparam int CLK_PERIOD = 10;
  localparam int GAP  = 3;
  localparam int SPAN = 9;
  localparam int MAXR = SPAN / GAP + 1;
  localparam int AW   = 16;

  logic clk = 0, rst_n = 0, start = 0, lay = 0, done, err, req, we, ack = 0;
  logic [1:0]  qidx = 0;
  logic [AW-1:0] addr;
  logic [31:0] wdata, rdata = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  qrst_seq #(.ADDR_W(AW), .QIDX_W(2), .POLL_GAP(GAP), .POLL_SPAN(SPAN)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .qidx_i(qidx), .layout_i(lay),
    .done_o(done), .error_o(err), .req_o(req), .we_o(we), .addr_o(addr),
    .wdata_o(wdata), .rdata_i(rdata), .ack_i(ack));

  int checks = 0, errors = 0;
  logic [31:0] regs [4][64];
  int lat = 0, wcnt = 0, cyc = 0, n1 = 0, n2 = 0, p1 = 0, p2 = 0;
  bit seen_rst = 0;
  int nlog = 0, ndone = 0;
  bit done_err = 0;
  logic        log_we [128];
  logic [15:0] log_addr [128];
  logic [31:0] log_data [128];
  int          log_cyc [128];
  int nexp = 0;
  logic        exp_we [128];
  logic [15:0] exp_addr [128];
  logic [31:0] exp_data [128];
  bit exp_err = 0;

  task automatic chk(bit ok, string req_tag, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req_tag, act, expv);
    end
  endtask

  // bus responder and done monitor, away from the active edge
  always @(negedge clk) begin
    cyc++;
    ack = 0;
    if (done) begin ndone++; done_err = err; end
    if (rst_n && req) begin
      if (wcnt < lat) wcnt++;
      else begin
        automatic int q = int'(addr[9:8]);
        automatic int ix = int'(addr[7:2]);
        wcnt = 0;
        if (nlog < 128) begin
          log_we[nlog] = we; log_addr[nlog] = addr; log_data[nlog] = wdata; log_cyc[nlog] = cyc;
          nlog++;
        end
        if (we) begin
          regs[q][ix] = wdata;
          if (addr[7:0] == 8'h24) seen_rst = 1;
        end else if (addr[7:0] == 8'h30) begin
          if (!seen_rst) begin rdata = (p1 < n1) ? 32'h5A5A_5A51 : 32'h5A5A_5A56; p1++; end
          else           begin rdata = (p2 < n2) ? 32'hA5A5_A5A2 : 32'hA5A5_A5A0; p2++; end
        end else rdata = regs[q][ix];
        ack = 1;
      end
    end
  end

  task automatic push(bit w, int a, logic [31:0] d);
    exp_we[nexp] = w; exp_addr[nexp] = 16'(a); exp_data[nexp] = d; nexp++;
  endtask

  task automatic build(int q, logic [31:0] i0, logic [31:0] i1);
    automatic int b = q * 256;
    automatic logic [31:0] c0 = i0;
    automatic int r;
    nexp = 0; exp_err = 0;
    push(0, b+'h20, 0); c0 = c0 | 32'h10; push(1, b+'h20, c0);
    push(0, b+'h20, 0); c0 = c0 & ~32'h1; push(1, b+'h20, c0);
    r = (n1 < MAXR) ? n1 + 1 : MAXR;
    for (int k = 0; k < r; k++) push(0, b+'h30, 0);
    if (n1 >= MAXR) begin exp_err = 1; return; end
    push(0, b+'h24, 0); push(1, b+'h24, i1 | 32'h1);
    push(1, b+'h0C, 0); push(1, b+'h1C, 0);
    push(0, b+'h20, 0); c0 = c0 & ~32'h10; push(1, b+'h20, c0);
    r = (n2 < MAXR) ? n2 + 1 : MAXR;
    for (int k = 0; k < r; k++) push(0, b+'h30, 0);
    if (n2 >= MAXR) exp_err = 1;
  endtask

  task automatic run_case(int q, bit l, int a1, int a2, int lt, int seed);
    automatic logic [31:0] i0 = {16'hC3C3, 8'(seed), 3'b000, seed[1], 3'b000, seed[0]};
    automatic logic [31:0] i1 = {8'h7E, 8'(seed * 3), 15'h0, seed[2]};
    automatic int t;
    n1 = a1; n2 = a2; p1 = 0; p2 = 0; seen_rst = 0; lat = lt; wcnt = 0;
    nlog = 0; ndone = 0;
    for (int qq = 0; qq < 4; qq++)
      for (int ii = 0; ii < 64; ii++) regs[qq][ii] = 32'hDEAD_0000 | 32'(ii);
    regs[q][8] = i0; regs[q][9] = i1;
    build(q, i0, i1);
    @(negedge clk); start = 1; qidx = 2'(q); lay = l;
    @(negedge clk); start = 0;
    repeat (4) @(negedge clk);
    start = 1; qidx = 2'(q ^ 1); lay = ~l;         // R9: must be ignored
    @(negedge clk); start = 0;
    t = 0;
    while (ndone == 0 && t < 3000) begin @(negedge clk); t++; end
    repeat (12) @(negedge clk);
    chk(ndone == 1, "R8 done pulse count", ndone, 1);
    chk(done_err == exp_err, "R7 error with done", done_err, exp_err);
    chk(err == exp_err, "R8 error held", err, exp_err);
    chk(nlog == nexp, "R9 access count", nlog, nexp);
    chk(!req, "R7 bus quiet after done", req, 0);
    for (int k = 0; k < nexp && k < nlog; k++) begin
      chk(log_addr[k] == exp_addr[k], "R1 address", log_addr[k], exp_addr[k]);
      chk(log_we[k] == exp_we[k], "R2 access order", log_we[k], exp_we[k]);
      if (exp_we[k]) chk(log_data[k] == exp_data[k], "R3 write data", log_data[k], exp_data[k]);
      if (k > 0 && !log_we[k] && log_addr[k][7:0] == 8'h30
          && !log_we[k-1] && log_addr[k-1][7:0] == 8'h30)
        chk(log_cyc[k] - log_cyc[k-1] == GAP + 1 + lt, "R6 poll interval",
            log_cyc[k] - log_cyc[k-1], GAP + 1 + lt);
    end
  endtask

  initial begin
    automatic int n1s[5] = '{0, 1, 3, 4, 6};   // R4 boundaries: MAXR-1 hits on last read
    automatic int n2s[4] = '{0, 2, 3, 4};      // R5 boundaries
    automatic int seed = 0;
    repeat (3) @(negedge clk);
    chk(!req && !done && !err, "R11 reset state", {req, done, err}, 0);
    rst_n = 1;
    for (int q = 0; q < 4; q++)
      for (int l = 0; l < 2; l++)
        for (int a = 0; a < 5; a++)
          for (int c = 0; c < 4; c++) begin
            run_case(q, l[0], n1s[a], n2s[c], seed % 3, seed);
            seed++;
          end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired act=1 exp=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule